// File: doc/BRIEF.md
# CPU Control Register Bank

This block is a Wishbone slave that holds the debug and boot settings of a small 8-bit processor core. It also applies those settings directly to the core's pins. It decodes four full 32-bit word addresses. The first holds a writable cycle counter that runs freely. The second holds a debug-options word. The remaining two hold boot-loader configuration words. The core, its SRAM and the boot-loader logic sit outside the block and appear only as ports.

The debug word steers three pieces of pin logic:
- A flag multiplexer can replace the data and control I/O strobes with status-word bits.
- A write-enable shaper can narrow the write strobe to one phase of the clock.
- A reset override lets software hold the core in reset or release it, whatever the external reset line does.

The boot words are brought out as a load address window, a chip-select bit index and a boot enable. The debug word also carries an SRAM enable, which is brought out as a pin.

The bus side is a two-state machine. In BUS_IDLE, a strobed cycle (cyc and stb high) fires the access and moves the machine to BUS_ACK. BUS_ACK raises ack for one cycle and always returns to BUS_IDLE. The access is committed on the edge that leaves BUS_IDLE. Read data is registered on that same edge and is held until the next read.

Top module: `cpu_ctrl_bank`

## Requirements
- R1: The counter at 0x30400000 increases by one on every clock edge that does not write it. A read returns the value it held just before the edge that commits the read.
- R2: A write to 0x30400000 loads the written value on the commit edge. Counting then resumes from it and wraps from 0xFFFFFFFF to 0.
- R3: The debug word at 0x30200000 stores bits 6:0 and reads back zero-extended. Its fields are:
  - bit0: flag debug
  - bit1: carry debug
  - bits3:2: write-enable mode
  - bit4: override enable
  - bit5: override level
  - bit6: SRAM enable
- R4: Boot word 1 at 0x30100000 stores 32 bits. It drives boot_start from bits 15:0 and boot_end from bits 31:16.
- R5: Boot word 2 at 0x30180000 stores bits 3:0 and reads back zero-extended. It drives boot_cs_index from bits 2:0 and boot_enable from bit 3.
- R6: A read of any other address returns 0. A write to any other address changes no register.
- R7: Each strobed cycle seen in BUS_IDLE gets wb_ack high for exactly the following cycle. wb_ack is then low for at least one cycle.
- R8: With debug bit0 set, data_strobe_out equals psw_cc[0] and ctrl_strobe_out equals psw_cc[1]. This holds whatever bit1 is.
- R9: With bit0 clear and bit1 set, data_strobe_out equals psw_carry and ctrl_strobe_out equals psw_idc. With both bits clear, the strobes pass through unchanged.
- R10: The write-enable mode controls cpu_we_out as follows:
  - Mode 0 passes cpu_we_in.
  - Mode 1 passes cpu_we_in only while clk is low.
  - Mode 2 passes cpu_we_in only while clk is high.
  - Mode 3 acts like mode 0.
- R11: While debug bit4 is set, cpu_rst_out equals debug bit5 (1 holds the core in reset). While bit4 is clear, cpu_rst_out follows ext_cpu_rst.
- R12: sram_enable equals debug bit6.
- R13: After rst, every register except the counter reads 0, all configuration outputs are 0, and wb_ack is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the bank, active high |
| wb_cyc | input | 1 | Bus cycle active |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | 1 for write, 0 for read |
| wb_adr | input | 32 | Byte address |
| wb_dat_w | input | 32 | Write data |
| wb_dat_r | output | 32 | Registered read data |
| wb_ack | output | 1 | One-cycle acknowledge |
| ext_cpu_rst | input | 1 | External core reset, active high |
| psw_cc | input | 2 | Status-word condition code bits |
| psw_carry | input | 1 | Status-word carry bit |
| psw_idc | input | 1 | Status-word inter-digit carry bit |
| cpu_data_strobe | input | 1 | Core data strobe |
| cpu_ctrl_strobe | input | 1 | Core control strobe |
| cpu_we_in | input | 1 | Core write-enable before shaping |
| data_strobe_out | output | 1 | Data strobe pin after the flag multiplexer |
| ctrl_strobe_out | output | 1 | Control strobe pin after the flag multiplexer |
| cpu_we_out | output | 1 | Shaped write-enable pin |
| cpu_rst_out | output | 1 | Core reset after the override |
| sram_enable | output | 1 | SRAM enable |
| boot_start | output | 16 | First boot load address (inclusive) |
| boot_end | output | 16 | Last boot load address (inclusive) |
| boot_cs_index | output | 3 | Port bit used as flash chip select |
| boot_enable | output | 1 | Boot loader enable |

## Verification
The pin logic is driven from a table of vectors, and each vector pairs a debug word with a set of core inputs.

The inputs are chosen so that each candidate source gives a different value:
- The two status-word mappings are told apart from each other.
- Both are told apart from a plain pass-through.
- With both debug bits set, the vector shows which mapping has priority.

The write-enable is sampled in both clock phases in every mode, which separates modes 1, 2 and 3.

Directed bus sequences cover the following cases:
- a counter load that wraps past its maximum
- a near-miss address
- a write to an unmapped location, followed by read-back of all registers
- a strobe held high, to show the acknowledge pattern

// File: rtl/cpuctl_pkg.sv
package cpuctl_pkg;

    // debug word field positions
    localparam int DBG_W        = 7;
    localparam int DBG_FLAG     = 0;
    localparam int DBG_CARRY    = 1;
    localparam int DBG_WE_LO    = 2;
    localparam int DBG_WE_HI    = 3;
    localparam int DBG_OVR_EN   = 4;
    localparam int DBG_OVR_LVL  = 5;
    localparam int DBG_SRAM     = 6;

    // boot word 2 field positions
    localparam int BOOT2_W      = 4;
    localparam int BOOT2_EN     = 3;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_e;

    typedef enum logic [1:0] {
        WE_FULL     = 2'd0,
        WE_CLK_LOW  = 2'd1,
        WE_CLK_HIGH = 2'd2,
        WE_FULL_ALT = 2'd3
    } we_mode_e;

endpackage

// File: rtl/cpuctl_bus_fsm.sv
module cpuctl_bus_fsm
    import cpuctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cyc,
    input  logic stb,
    output logic fire,
    output logic ack
);

    bus_state_e state_q;
    bus_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (cyc && stb) state_d = BUS_ACK;
            BUS_ACK:  state_d = BUS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= BUS_IDLE;
        else     state_q <= state_d;
    end

    // outputs
    always_comb begin
        fire = 1'b0;
        ack  = 1'b0;
        unique case (state_q)
            BUS_IDLE: fire = cyc && stb;
            BUS_ACK:  ack  = 1'b1;
        endcase
    end

endmodule

// File: rtl/cpuctl_regs.sv
module cpuctl_regs
    import cpuctl_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int BOOT_ADDR_W = 16,
    parameter int CS_IDX_W    = 3,
    parameter logic [ADDR_W-1:0] CNT_ADDR   = 32'h3040_0000,
    parameter logic [ADDR_W-1:0] DBG_ADDR   = 32'h3020_0000,
    parameter logic [ADDR_W-1:0] BOOT1_ADDR = 32'h3010_0000,
    parameter logic [ADDR_W-1:0] BOOT2_ADDR = 32'h3018_0000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   fire,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      adr,
    input  logic [DATA_W-1:0]      wdat,
    output logic [DATA_W-1:0]      rdata,
    output logic [DATA_W-1:0]      cnt,
    output logic [DBG_W-1:0]       dbg,
    output logic [BOOT_ADDR_W-1:0] boot_start,
    output logic [BOOT_ADDR_W-1:0] boot_end,
    output logic [CS_IDX_W-1:0]    cs_index,
    output logic                   boot_en
);

    localparam int BOOT1_W = 2 * BOOT_ADDR_W;

    logic                 hit_cnt, hit_dbg, hit_b1, hit_b2;
    logic                 wr, rd;
    logic [BOOT1_W-1:0]   boot1_q;
    logic [BOOT2_W-1:0]   boot2_q;
    logic [DATA_W-1:0]    rd_mux;

    always_comb begin
        hit_cnt = (adr == CNT_ADDR);
        hit_dbg = (adr == DBG_ADDR);
        hit_b1  = (adr == BOOT1_ADDR);
        hit_b2  = (adr == BOOT2_ADDR);
        wr      = fire && we;
        rd      = fire && !we;
    end

    always_comb begin
        rd_mux = '0;
        if (hit_cnt) rd_mux = cnt;
        if (hit_dbg) rd_mux = DATA_W'(dbg);
        if (hit_b1)  rd_mux = DATA_W'(boot1_q);
        if (hit_b2)  rd_mux = DATA_W'(boot2_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            dbg     <= '0;
            boot1_q <= '0;
            boot2_q <= '0;
            rdata   <= '0;
        end else begin
            if (wr && hit_cnt) cnt <= wdat;
            else               cnt <= cnt + 1'b1;
            if (wr && hit_dbg) dbg     <= wdat[DBG_W-1:0];
            if (wr && hit_b1)  boot1_q <= wdat[BOOT1_W-1:0];
            if (wr && hit_b2)  boot2_q <= wdat[BOOT2_W-1:0];
            if (rd)            rdata   <= rd_mux;
        end
    end

    always_comb begin
        boot_start = boot1_q[BOOT_ADDR_W-1:0];
        boot_end   = boot1_q[BOOT1_W-1:BOOT_ADDR_W];
        cs_index   = boot2_q[CS_IDX_W-1:0];
        boot_en    = boot2_q[BOOT2_EN];
    end

endmodule

// File: rtl/cpuctl_pin_shaper.sv
module cpuctl_pin_shaper
    import cpuctl_pkg::*;
(
    input  logic             clk,
    input  logic [DBG_W-1:0] dbg,
    input  logic [1:0]       psw_cc,
    input  logic             psw_carry,
    input  logic             psw_idc,
    input  logic             data_in,
    input  logic             ctrl_in,
    input  logic             we_in,
    input  logic             ext_rst,
    output logic             data_out,
    output logic             ctrl_out,
    output logic             we_out,
    output logic             rst_out,
    output logic             sram_en
);

    we_mode_e mode;

    // flag multiplexer; flag mapping wins over carry mapping
    always_comb begin
        data_out = data_in;
        ctrl_out = ctrl_in;
        if (dbg[DBG_FLAG]) begin
            data_out = psw_cc[0];
            ctrl_out = psw_cc[1];
        end else if (dbg[DBG_CARRY]) begin
            data_out = psw_carry;
            ctrl_out = psw_idc;
        end
    end

    // write-enable phase gating
    always_comb begin
        mode = we_mode_e'(dbg[DBG_WE_HI:DBG_WE_LO]);
        unique case (mode)
            WE_CLK_LOW:  we_out = we_in && !clk;
            WE_CLK_HIGH: we_out = we_in && clk;
            default:     we_out = we_in;
        endcase
    end

    always_comb begin
        rst_out = dbg[DBG_OVR_EN] ? dbg[DBG_OVR_LVL] : ext_rst;
        sram_en = dbg[DBG_SRAM];
    end

endmodule

// File: rtl/cpu_ctrl_bank.sv
module cpu_ctrl_bank
    import cpuctl_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int BOOT_ADDR_W = 16,
    parameter int CS_IDX_W    = 3,
    parameter logic [ADDR_W-1:0] CNT_ADDR   = 32'h3040_0000,
    parameter logic [ADDR_W-1:0] DBG_ADDR   = 32'h3020_0000,
    parameter logic [ADDR_W-1:0] BOOT1_ADDR = 32'h3010_0000,
    parameter logic [ADDR_W-1:0] BOOT2_ADDR = 32'h3018_0000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wb_cyc,
    input  logic                   wb_stb,
    input  logic                   wb_we,
    input  logic [ADDR_W-1:0]      wb_adr,
    input  logic [DATA_W-1:0]      wb_dat_w,
    output logic [DATA_W-1:0]      wb_dat_r,
    output logic                   wb_ack,
    input  logic                   ext_cpu_rst,
    input  logic [1:0]             psw_cc,
    input  logic                   psw_carry,
    input  logic                   psw_idc,
    input  logic                   cpu_data_strobe,
    input  logic                   cpu_ctrl_strobe,
    input  logic                   cpu_we_in,
    output logic                   data_strobe_out,
    output logic                   ctrl_strobe_out,
    output logic                   cpu_we_out,
    output logic                   cpu_rst_out,
    output logic                   sram_enable,
    output logic [BOOT_ADDR_W-1:0] boot_start,
    output logic [BOOT_ADDR_W-1:0] boot_end,
    output logic [CS_IDX_W-1:0]    boot_cs_index,
    output logic                   boot_enable
);

    logic              fire;
    logic [DATA_W-1:0] cnt_val;
    logic [DBG_W-1:0]  dbg_val;

    cpuctl_bus_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .cyc  (wb_cyc),
        .stb  (wb_stb),
        .fire (fire),
        .ack  (wb_ack)
    );

    cpuctl_regs #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .BOOT_ADDR_W (BOOT_ADDR_W),
        .CS_IDX_W    (CS_IDX_W),
        .CNT_ADDR    (CNT_ADDR),
        .DBG_ADDR    (DBG_ADDR),
        .BOOT1_ADDR  (BOOT1_ADDR),
        .BOOT2_ADDR  (BOOT2_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .we         (wb_we),
        .adr        (wb_adr),
        .wdat       (wb_dat_w),
        .rdata      (wb_dat_r),
        .cnt        (cnt_val),
        .dbg        (dbg_val),
        .boot_start (boot_start),
        .boot_end   (boot_end),
        .cs_index   (boot_cs_index),
        .boot_en    (boot_enable)
    );

    cpuctl_pin_shaper u_pins (
        .clk       (clk),
        .dbg       (dbg_val),
        .psw_cc    (psw_cc),
        .psw_carry (psw_carry),
        .psw_idc   (psw_idc),
        .data_in   (cpu_data_strobe),
        .ctrl_in   (cpu_ctrl_strobe),
        .we_in     (cpu_we_in),
        .ext_rst   (ext_cpu_rst),
        .data_out  (data_strobe_out),
        .ctrl_out  (ctrl_strobe_out),
        .we_out    (cpu_we_out),
        .rst_out   (cpu_rst_out),
        .sram_en   (sram_enable)
    );

endmodule

// File: rtl/cpu_ctrl_bank_chk.sv
module cpu_ctrl_bank_chk
    import cpuctl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CNT_ADDR   = 32'h3040_0000,
    parameter logic [ADDR_W-1:0] DBG_ADDR   = 32'h3020_0000,
    parameter logic [ADDR_W-1:0] BOOT1_ADDR = 32'h3010_0000,
    parameter logic [ADDR_W-1:0] BOOT2_ADDR = 32'h3018_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              wb_cyc,
    input logic              wb_stb,
    input logic              wb_we,
    input logic [ADDR_W-1:0] wb_adr,
    input logic [DATA_W-1:0] wb_dat_r,
    input logic              wb_ack,
    input logic [DATA_W-1:0] cnt_val,
    input logic [DBG_W-1:0]  dbg_val,
    input logic [1:0]        psw_cc,
    input logic              data_strobe_out,
    input logic              ctrl_strobe_out,
    input logic              cpu_rst_out
);

    logic req, unmapped, cnt_wr;
    always_comb begin
        req      = wb_cyc && wb_stb && !wb_ack;
        unmapped = (wb_adr != CNT_ADDR) && (wb_adr != DBG_ADDR) &&
                   (wb_adr != BOOT1_ADDR) && (wb_adr != BOOT2_ADDR);
        cnt_wr   = req && wb_we && (wb_adr == CNT_ADDR);
    end

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr |=> cnt_val == $past(cnt_val) + 1'b1);

    // R6
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !wb_we && unmapped) |=> wb_dat_r == '0);

    // R7
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> wb_ack);

    // R7
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        wb_ack |=> !wb_ack);

    // R8
    flag_mux_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_val[DBG_FLAG] |-> (data_strobe_out == psw_cc[0]) &&
                              (ctrl_strobe_out == psw_cc[1]));

    // R11
    rst_override_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_val[DBG_OVR_EN] |-> cpu_rst_out == dbg_val[DBG_OVR_LVL]);

endmodule

bind cpu_ctrl_bank cpu_ctrl_bank_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CNT_ADDR   (CNT_ADDR),
    .DBG_ADDR   (DBG_ADDR),
    .BOOT1_ADDR (BOOT1_ADDR),
    .BOOT2_ADDR (BOOT2_ADDR)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .wb_cyc          (wb_cyc),
    .wb_stb          (wb_stb),
    .wb_we           (wb_we),
    .wb_adr          (wb_adr),
    .wb_dat_r        (wb_dat_r),
    .wb_ack          (wb_ack),
    .cnt_val         (cnt_val),
    .dbg_val         (dbg_val),
    .psw_cc          (psw_cc),
    .data_strobe_out (data_strobe_out),
    .ctrl_strobe_out (ctrl_strobe_out),
    .cpu_rst_out     (cpu_rst_out)
);

// File: tb/cpu_ctrl_bank_test.sv
module cpu_ctrl_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] A_CNT = 32'h3040_0000;
    localparam logic [31:0] A_DBG = 32'h3020_0000;
    localparam logic [31:0] A_B1  = 32'h3010_0000;
    localparam logic [31:0] A_B2  = 32'h3018_0000;

    // {dbg[6:0], cc[1:0], carry, idc, data_in, ctrl_in, we_in, exp_data, exp_ctrl, exp_we_high, exp_we_low}
    localparam int NVEC = 8;
    localparam logic [17:0] VEC [NVEC] = '{
        {7'h00, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'b1011},
        {7'h01, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0111},
        {7'h02, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1011},
        {7'h03, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0111},
        {7'h04, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0101},
        {7'h08, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0110},
        {7'h0C, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0111},
        {7'h08, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0100}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
    logic [31:0] wb_adr = '0, wb_dat_w = '0;
    logic [31:0] wb_dat_r;
    logic        wb_ack;
    logic        ext_cpu_rst = 1'b0;
    logic [1:0]  psw_cc = '0;
    logic        psw_carry = 1'b0, psw_idc = 1'b0;
    logic        cpu_data_strobe = 1'b0, cpu_ctrl_strobe = 1'b0, cpu_we_in = 1'b0;
    logic        data_strobe_out, ctrl_strobe_out, cpu_we_out, cpu_rst_out, sram_enable;
    logic [15:0] boot_start, boot_end;
    logic [2:0]  boot_cs_index;
    logic        boot_enable;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_ctrl_bank uut (
        .clk(clk), .rst(rst),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
        .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack),
        .ext_cpu_rst(ext_cpu_rst), .psw_cc(psw_cc), .psw_carry(psw_carry),
        .psw_idc(psw_idc), .cpu_data_strobe(cpu_data_strobe),
        .cpu_ctrl_strobe(cpu_ctrl_strobe), .cpu_we_in(cpu_we_in),
        .data_strobe_out(data_strobe_out), .ctrl_strobe_out(ctrl_strobe_out),
        .cpu_we_out(cpu_we_out), .cpu_rst_out(cpu_rst_out),
        .sram_enable(sram_enable), .boot_start(boot_start), .boot_end(boot_end),
        .boot_cs_index(boot_cs_index), .boot_enable(boot_enable)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge; the access commits on the next rising edge
    task automatic wb_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b1; wb_adr = a; wb_dat_w = d;
        @(posedge clk);
        @(negedge clk);
        chk("R7 write ack", 32'(wb_ack), 32'd1);
        wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
        @(posedge clk);
    endtask

    task automatic wb_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b0; wb_adr = a;
        @(posedge clk);
        @(negedge clk);
        chk("R7 read ack", 32'(wb_ack), 32'd1);
        d = wb_dat_r;
        wb_cyc = 1'b0; wb_stb = 1'b0;
        @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r, r2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13 reset state
        chk("R13 ack", 32'(wb_ack), 32'd0);
        chk("R13 dat_r", wb_dat_r, 32'd0);
        chk("R13 boot", {boot_start, boot_end}, 32'd0);
        chk("R13 boot2", {27'd0, boot_enable, boot_cs_index, sram_enable}, 32'd0);
        ext_cpu_rst = 1'b1;
        #1 chk("R13 R11 rst follows ext", 32'(cpu_rst_out), 32'd1);
        ext_cpu_rst = 1'b0;
        rst = 1'b0;
        wb_read(A_DBG, r);  chk("R13 dbg reads 0", r, 32'd0);
        wb_read(A_B1, r);   chk("R13 boot1 reads 0", r, 32'd0);
        wb_read(A_B2, r);   chk("R13 boot2 reads 0", r, 32'd0);

        // R1 counter free-runs: reads two edges apart differ by 2
        wb_read(A_CNT, r);
        wb_read(A_CNT, r2);
        chk("R1 counter step", r2 - r, 32'd2);

        // R2 load then resume; and wrap
        wb_write(A_CNT, 32'h1234_5670);
        wb_read(A_CNT, r);  chk("R2 counter load", r, 32'h1234_5671);
        wb_write(A_CNT, 32'hFFFF_FFFF);
        wb_read(A_CNT, r);  chk("R2 counter wrap", r, 32'h0000_0000);

        // R4 boot word 1
        wb_write(A_B1, 32'h0FFF_0000);
        chk("R4 boot_start", 32'(boot_start), 32'd0);
        chk("R4 boot_end", 32'(boot_end), 32'd4095);
        wb_read(A_B1, r);   chk("R4 boot1 readback", r, 32'h0FFF_0000);

        // R5 boot word 2
        wb_write(A_B2, 32'hFFFF_FFFF);
        chk("R5 cs index", 32'(boot_cs_index), 32'd7);
        chk("R5 boot enable", 32'(boot_enable), 32'd1);
        wb_read(A_B2, r);   chk("R5 boot2 readback", r, 32'h0000_000F);
        wb_write(A_B2, 32'h0000_0005);
        chk("R5 cs index 5", {28'd0, boot_enable, boot_cs_index}, 32'd5);

        // R3 debug word readback, R12 sram enable
        wb_write(A_DBG, 32'hFFFF_FFC1);
        wb_read(A_DBG, r);  chk("R3 dbg readback", r, 32'h0000_0041);
        chk("R12 sram on", 32'(sram_enable), 32'd1);

        // R6 unmapped write ignored and read zero
        wb_write(32'h3030_0000, 32'hFFFF_FFFF);
        wb_write(32'h3040_0004, 32'hFFFF_FFFF);
        wb_read(A_DBG, r);  chk("R6 dbg untouched", r, 32'h0000_0041);
        wb_read(A_B1, r);   chk("R6 boot1 untouched", r, 32'h0FFF_0000);
        wb_read(A_B2, r);   chk("R6 boot2 untouched", r, 32'h0000_0005);
        wb_read(32'h3040_0004, r); chk("R6 near-miss reads 0", r, 32'd0);
        wb_read(32'h0000_0000, r); chk("R6 zero addr reads 0", r, 32'd0);

        // R8 R9 R10 vector table for the pin logic
        for (int i = 0; i < NVEC; i++) begin
            wb_write(A_DBG, {25'd0, VEC[i][17:11]});
            @(negedge clk);
            psw_cc = VEC[i][10:9]; psw_carry = VEC[i][8]; psw_idc = VEC[i][7];
            cpu_data_strobe = VEC[i][6]; cpu_ctrl_strobe = VEC[i][5]; cpu_we_in = VEC[i][4];
            #2;
            chk($sformatf("R10 we clk low vec%0d", i), 32'(cpu_we_out), 32'(VEC[i][0]));
            @(posedge clk);
            #2;
            chk($sformatf("R8 R9 data strobe vec%0d", i), 32'(data_strobe_out), 32'(VEC[i][3]));
            chk($sformatf("R8 R9 ctrl strobe vec%0d", i), 32'(ctrl_strobe_out), 32'(VEC[i][2]));
            chk($sformatf("R10 we clk high vec%0d", i), 32'(cpu_we_out), 32'(VEC[i][1]));
        end

        // R11 reset override
        ext_cpu_rst = 1'b1;
        wb_write(A_DBG, 32'h10);
        #1 chk("R11 override release", 32'(cpu_rst_out), 32'd0);
        ext_cpu_rst = 1'b0;
        wb_write(A_DBG, 32'h30);
        #1 chk("R11 override hold", 32'(cpu_rst_out), 32'd1);
        wb_write(A_DBG, 32'h20);
        #1 chk("R11 disabled passes ext", 32'(cpu_rst_out), 32'd0);
        chk("R12 sram off", 32'(sram_enable), 32'd0);

        // R7 strobe held high: ack 1,0,1
        @(negedge clk);
        wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b0; wb_adr = A_DBG;
        @(posedge clk); @(negedge clk); chk("R7 held ack 1", 32'(wb_ack), 32'd1);
        @(posedge clk); @(negedge clk); chk("R7 held ack 0", 32'(wb_ack), 32'd0);
        @(posedge clk); @(negedge clk); chk("R7 held ack 1 again", 32'(wb_ack), 32'd1);
        wb_cyc = 1'b0; wb_stb = 1'b0;
        @(posedge clk); @(negedge clk); chk("R7 idle no ack", 32'(wb_ack), 32'd0);

        // R13 reset clears configuration again
        wb_write(A_B2, 32'hF);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R13 reset clears boot2", {28'd0, boot_enable, boot_cs_index}, 32'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule